// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a phase-locked loop whose VCO is first divided by a dual-modulus prescaler. The prescaler divides by either P or P+1. Its output clocks this block. The block holds two down-counters. The swallow counter keeps the prescaler on P+1 for the first S prescaler cycles of each division period. The main counter sets the length of the period to M prescaler cycles. The period therefore spans N = P·M + S VCO cycles. At the end of each period the block emits a comparison pulse, one prescaler cycle wide, for the phase detector.

Three settings come in already latched: the swallow value S (0 to 127), the main value M (5 to 2047) and a pair-select bit. The pair-select bit tells the prescaler which modulus pair to use, for example 16/17 against 32/33 or 64/65 against 128/129. The block takes a fresh copy of all three at each period boundary. Software can therefore rewrite the latches at any time without producing a broken period.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `fp`, `mod_hi` and `pair_sel` are all 0. The first rising `clk` edge after reset loads the settings.
- R2: `fp` is high for exactly one `clk` cycle per division period. A period lasts M `clk` cycles, where M is the loaded `count_ld`.
- R3: `mod_hi` is 1 for the first S `clk` cycles of a period and 0 for the rest of it. It never rises again inside a period. Here S is the loaded `swallow_ld` and S ≤ M. With a prescaler that divides by P+1 when `mod_hi`=1, the period spans P·M + S prescaler input cycles.
- R4: Changes on `swallow_ld`, `count_ld` or `pair_ld` in the middle of a period do not alter that period. They apply from the next period onward.
- R5: `pair_sel` takes the value of `pair_ld` at each period boundary and holds it for the whole period. In the bench, 0 selects the 16/17 pair and 1 selects the 32/33 pair.
- R6: If S ≥ M, `mod_hi` stays 1 for the whole period, so the period spans (P+1)·M input cycles.
- R7: A `count_ld` below 5 is loaded as 5.
- R8: With S = 0, `mod_hi` stays 0 for the whole period, so the period spans P·M input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_ld | input | 7 | Latched swallow value S |
| count_ld | input | 11 | Latched main counter value M |
| pair_ld | input | 1 | Latched modulus-pair select |
| mod_hi | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| fp | output | 1 | Divided comparison pulse, one clock wide per period |
| pair_sel | output | 1 | Pair select to the prescaler, updated at period boundaries |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. These are: `fp` is never high on two cycles in a row, `mod_hi` never rises inside a period, `pair_sel` never moves away from a boundary, the main count after a load is at least 5, and `mod_hi` holds while the remaining swallow count covers the rest of the period. Some properties span a whole period or the path through the prescaler, and only the bench scenarios can show them. These are the total count P·M + S of input cycles, the number of `mod_hi` cycles, that a mid-period rewrite takes effect one period late, and the clamp and over-swallow cases. The bench shows them by driving a behavioural P/P+1 prescaler from a fast clock and counting its cycles between boundaries.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int SW_W   = 7,
  parameter int PG_W   = 11,
  parameter int PG_MIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] swallow_ld,
  input  logic [PG_W-1:0] count_ld,
  input  logic            pair_ld,
  output logic            mod_hi,
  output logic            fp,
  output logic            pair_sel
);
  localparam logic [PG_W-1:0] MIN_CNT = PG_W'(PG_MIN);

  logic [PG_W-1:0] pcnt;
  logic [SW_W-1:0] scnt;

  wire             boundary = (pcnt <= PG_W'(1));
  wire [PG_W-1:0]  cnt_eff  = (count_ld < MIN_CNT) ? MIN_CNT : count_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      scnt     <= '0;
      pair_sel <= 1'b0;
    end else if (boundary) begin
      pcnt     <= cnt_eff;
      scnt     <= swallow_ld;
      pair_sel <= pair_ld;
    end else begin
      pcnt <= pcnt - PG_W'(1);
      if (scnt != '0) scnt <= scnt - SW_W'(1);
    end
  end

  assign mod_hi = (scnt != '0);
  assign fp     = (pcnt == PG_W'(1));

  assert_fp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  assert_mod_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !mod_hi) |=> !mod_hi);

  assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(pair_sel));

  assert_full_swallow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && PG_W'(scnt) >= pcnt) |=> mod_hi);

  assert_min_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (pcnt >= MIN_CNT));

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!fp && !mod_hi);
  end
endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
  localparam longint LIMIT = 190000;

  logic fin = 1'b0;
  always #2 fin = ~fin;

  logic        rst_n = 1'b0;
  logic [6:0]  sw = '0;
  logic [10:0] pg = 11'd5;
  logic        sel = 1'b0;
  logic        pclk = 1'b0;
  logic        mod_hi, fp, pair_sel;

  pulse_swallow_div u0 (
    .clk(pclk), .rst_n(rst_n), .swallow_ld(sw), .count_ld(pg), .pair_ld(sel),
    .mod_hi(mod_hi), .fp(fp), .pair_sel(pair_sel));

  int unsigned pre_cnt = 0;
  always @(posedge fin) begin
    int unsigned modv;
    modv = (pair_sel ? 32 : 16) + (mod_hi ? 1 : 0);
    if (pre_cnt + 1 >= modv) begin pre_cnt <= 0; pclk <= 1'b1; end
    else begin pre_cnt <= pre_cnt + 1; pclk <= 1'b0; end
  end

  longint fin_cnt = 0;
  always @(posedge fin) fin_cnt <= fin_cnt + 1;

  int pc_cnt = 0, mh_cnt = 0, fh_cnt = 0;
  always @(negedge pclk) begin
    pc_cnt <= pc_cnt + 1;
    if (mod_hi) mh_cnt <= mh_cnt + 1;
    if (fp) fh_cnt <= fh_cnt + 1;
  end

  int checks = 0, fails = 0;
  longint s_fin; int s_pc, s_mh, s_fh; logic s_pair;
  longint m_n; int m_cyc, m_mh, m_fh; logic m_pair;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic snap();
    #1;
    s_fin = fin_cnt; s_pc = pc_cnt; s_mh = mh_cnt; s_fh = fh_cnt; s_pair = pair_sel;
  endtask

  task automatic sync();
    @(negedge fp); snap();
  endtask

  task automatic period_end();
    @(negedge fp); #1;
    m_n = fin_cnt - s_fin; m_cyc = pc_cnt - s_pc; m_mh = mh_cnt - s_mh;
    m_fh = fh_cnt - s_fh; m_pair = s_pair;
    s_fin = fin_cnt; s_pc = pc_cnt; s_mh = mh_cnt; s_fh = fh_cnt; s_pair = pair_sel;
  endtask

  function automatic int eff_m(int m); return (m < 5) ? 5 : m; endfunction
  function automatic int eff_s(int s, int m); return (s > eff_m(m)) ? eff_m(m) : s; endfunction
  function automatic longint exp_n(int s, int m, bit p);
    return longint'(p ? 32 : 16) * eff_m(m) + eff_s(s, m);
  endfunction

  task automatic expect_period(string req, int s, int m, bit p);
    chk({req, " input cycles"}, m_n, exp_n(s, m, p));
    chk({"R2 period length ", req}, m_cyc, eff_m(m));
    chk({"R2 fp width ", req}, m_fh, 1);
    chk({"R3 mod_hi cycles ", req}, m_mh, eff_s(s, m));
    chk({"R5 pair_sel ", req}, m_pair, p);
  endtask

  task automatic run_case(string req, int s, int m, bit p);
    sw = 7'(s); pg = 11'(m); sel = p;
    sync(); period_end();
    expect_period(req, s, m, p);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (50) @(posedge fin);
    #1;
    chk("R1 fp in reset", fp, 0);
    chk("R1 mod_hi in reset", mod_hi, 0);
    chk("R1 pair_sel in reset", pair_sel, 0);
    @(negedge fin); rst_n = 1'b1;

    run_case("R3 basic", 3, 10, 0);
    run_case("R8 zero swallow", 0, 12, 1);
    run_case("R3 swallow equals main", 9, 9, 0);
    run_case("R6 swallow above main", 60, 10, 1);
    run_case("R7 main below minimum", 1, 2, 0);
    run_case("R7 main zero", 3, 0, 1);
    run_case("R5 pair switch", 4, 7, 0);

    sw = 7'd5; pg = 11'd20; sel = 1'b0;
    sync();
    repeat (3) @(negedge pclk);
    sw = 7'd1; pg = 11'd9; sel = 1'b1;
    period_end();
    expect_period("R4 old values kept", 5, 20, 0);
    period_end();
    expect_period("R4 new values", 1, 9, 1);

    for (int i = 0; i < 25; i++) begin
      int m, s; bit p;
      m = $urandom_range(40, 5);
      s = ($urandom_range(7, 0) == 0) ? $urandom_range(127, 0) : $urandom_range(m, 0);
      p = 1'($urandom_range(1, 0));
      run_case(s > m ? "R6 random" : "R3 random", s, m, p);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (fin_cnt >= LIMIT);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected below %0d", fin_cnt, LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule